// File: doc/BRIEF.md
# Scanline Interrupt Event Controller

This block keeps the vertical line count of a video frame and turns line and beam events into interrupt requests for a CPU core. An end-of-line strobe advances the counter. The counter wraps at one of two frame lengths, chosen by a video-standard select input. Each wrap flips a field status bit. The block also keeps a vertical-blank status bit, which sets on the first line below the visible screen and clears on the first visible line.

On entry to vertical blank, and only when the NMI is enabled, the block arms an NMI countdown loaded from a programmable trigger value. When the countdown expires, the block emits a one-cycle NMI pulse. Reaching the first visible line before expiry cancels the pending NMI.

Beam-position IRQs come from two sources:
- a vertical-only match, checked at end of line;
- a horizontal timer match, optionally gated by the target line.

A raised source starts a short delay before the IRQ is delivered. The delay is skipped when the CPU reports that it is waiting for an interrupt, and in that case a wake pulse goes out at once. While the CPU masks IRQs, a due IRQ stays pending. Clearing every source withdraws a pending IRQ.

Top module: `scanline_irq_ctrl`

## Requirements
- R1: The line counter starts at 0 after reset and advances by one on each end-of-line strobe. On a strobe that would reach the frame length it returns to 0 instead. The frame length is NTSC_LINES when palSel is 0 and PAL_LINES when palSel is 1.
- R2: fieldFlag toggles on every end-of-line strobe that wraps the line counter to 0, and holds at all other times.
- R3: vblankFlag sets on the strobe whose new line equals screenHeight + FIRST_VIS. It clears on the strobe whose new line equals FIRST_VIS. It is 0 after reset.
- R4: When nmiEnable is 1 on the strobe that enters vertical blank, nmiPulse rises for one cycle after T further clock edges, where T = max(nmiTrigger, 1). Relative to the entering strobe's edge that is edge count T+1.
- R5: No NMI is produced for a vertical-blank entry while nmiEnable is 0. A pending NMI is cancelled, with no pulse, if a strobe reaches line FIRST_VIS before it fires.
- R6: When the NMI fires while cpuWaiting is 1, wakePulse is asserted in the same cycle as nmiPulse.
- R7: With vTimerEn=1 and hTimerEn=0, an end-of-line strobe whose new line equals irqLine raises the vertical source (irqSrcClr bit 1). hTimerStb then raises nothing.
- R8: A hTimerStb with hTimerEn=1 raises the horizontal source (irqSrcClr bit 0) when vTimerEn=0, or when the current line equals irqLine. With hTimerEn=0, hTimerStb raises nothing.
- R9: A raised source, with cpuWaiting=0 and cpuIrqMask=0, produces a single irqPulse on the fifth clock edge counting the raising edge as the first.
- R10: A source raised while cpuWaiting=1 gives wakePulse right after the raising edge, and irqPulse on the next edge.
- R11: While cpuIrqMask is 1 a due IRQ is not delivered and stays pending. After the mask drops, irqPulse follows on the second clock edge.
- R12: Setting an irqSrcClr bit removes that source. If no source is left when the delay ends, the pending IRQ is dropped with no pulse. Clearing only another source does not stop delivery.
- R13: After reset, nmiPulse, irqPulse, wakePulse, vblankFlag and fieldFlag are all 0, and each pulse output lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| lineEndStb | input | 1 | One-cycle end-of-line strobe |
| hTimerStb | input | 1 | One-cycle horizontal timer match strobe |
| palSel | input | 1 | Frame length select: 0 NTSC_LINES, 1 PAL_LINES |
| screenHeight | input | LINE_W | Visible screen height in lines |
| hTimerEn | input | 1 | Horizontal beam timer enable |
| vTimerEn | input | 1 | Vertical beam timer enable |
| irqLine | input | LINE_W | Target line for beam IRQs |
| irqSrcClr | input | 2 | Source clear: bit 0 horizontal, bit 1 vertical |
| nmiEnable | input | 1 | Vertical-blank NMI enable |
| nmiTrigger | input | NMI_W | NMI countdown load value |
| cpuIrqMask | input | 1 | CPU IRQ mask flag |
| cpuWaiting | input | 1 | CPU is waiting for an interrupt |
| nmiPulse | output | 1 | One-cycle NMI request |
| irqPulse | output | 1 | One-cycle IRQ request |
| wakePulse | output | 1 | One-cycle wake for a waiting CPU |
| vblankFlag | output | 1 | Vertical-blank status |
| fieldFlag | output | 1 | Field toggle status |

## Verification
The bench builds the block with a 5-bit line counter, frames of 12 and 15 lines, FIRST_VIS of 1 and a 3-bit NMI countdown. With these values a whole frame takes only a few hundred cycles, so the bench can run complete frames for each case. It sweeps every IRQ target line of a frame in vertical-only mode, every NMI trigger value including zero, and every line in the horizontal-only, gated and disabled timer modes. For each strobe it computes the expected vblank state, field state and pulse edge counts from a line model of its own.

// File: rtl/scanirq_pkg.sv
package scanirq_pkg;

  // Source bit positions; the irqSrcClr port uses the same positions.
  localparam int SRC_H = 0;
  localparam int SRC_V = 1;
  localparam int SRC_W = 2;

  // Strobes from control to datapath.
  typedef struct packed {
    logic lineAdv;     // advance line counter
    logic nmiLoad;     // load NMI countdown from trigger
    logic nmiDec;      // step NMI countdown
    logic irqLoad;     // load IRQ delay
    logic irqLoadNow;  // with irqLoad: load zero instead of full delay
    logic irqDec;      // step IRQ delay
  } ctlStrobes_t;

  // Decoded datapath state back to control.
  typedef struct packed {
    logic wrapNext;       // next line value is a wrap to 0
    logic vbStartNext;    // next line is first blanking line
    logic firstVisNext;   // next line is first visible line
    logic vMatchNext;     // next line equals target line
    logic hMatchNow;      // current line equals target line
    logic nmiCntLastOne;  // NMI countdown at its final step
    logic irqDelayZero;   // IRQ delay expired
    logic irqDelayOne;    // IRQ delay one step from expiry
  } dpStatus_t;

endpackage

// File: rtl/sirq_datapath.sv
module sirq_datapath
  import scanirq_pkg::*;
#(
  parameter int LINE_W     = 9,
  parameter int NTSC_LINES = 262,
  parameter int PAL_LINES  = 312,
  parameter int FIRST_VIS  = 1,
  parameter int NMI_W      = 4,
  parameter int IRQ_DELAY  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              palSel,
  input  logic [LINE_W-1:0] screenHeight,
  input  logic [LINE_W-1:0] irqLine,
  input  logic [NMI_W-1:0]  nmiTrigger,
  input  ctlStrobes_t       stb,
  output dpStatus_t         status
);

  localparam int CNT_W = LINE_W + 1;
  localparam int DLY_W = $clog2(IRQ_DELAY + 1);
  localparam int MAX_LINES = (PAL_LINES > NTSC_LINES) ? PAL_LINES : NTSC_LINES;
  localparam logic [CNT_W-1:0] NTSC_LIM = CNT_W'(NTSC_LINES);
  localparam logic [CNT_W-1:0] PAL_LIM  = CNT_W'(PAL_LINES);
  localparam logic [CNT_W-1:0] ANY_LIM  = CNT_W'(MAX_LINES);
  localparam logic [LINE_W-1:0] FIRST_LINE = LINE_W'(FIRST_VIS);
  localparam logic [DLY_W-1:0] DLY_FULL = DLY_W'(IRQ_DELAY);

  logic [LINE_W-1:0] lineCount;
  logic [LINE_W-1:0] nextLine;
  logic [CNT_W-1:0]  incWide;
  logic [CNT_W-1:0]  frameLim;
  logic [CNT_W-1:0]  blankLine;
  logic              wrapNow;
  logic [NMI_W-1:0]  nmiCnt;
  logic [DLY_W-1:0]  irqDelay;

  // Line arithmetic: decode is done on the value the counter will take.
  always_comb begin
    incWide   = CNT_W'(lineCount) + CNT_W'(1);
    frameLim  = palSel ? PAL_LIM : NTSC_LIM;
    wrapNow   = (incWide >= frameLim);
    nextLine  = wrapNow ? '0 : incWide[LINE_W-1:0];
    blankLine = CNT_W'(screenHeight) + CNT_W'(FIRST_VIS);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineCount <= '0;
    end else if (stb.lineAdv) begin
      lineCount <= nextLine;
    end
  end

  // NMI countdown register.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiCnt <= '0;
    end else if (stb.nmiLoad) begin
      nmiCnt <= nmiTrigger;
    end else if (stb.nmiDec) begin
      nmiCnt <= nmiCnt - NMI_W'(1);
    end
  end

  // IRQ delivery delay register.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqDelay <= '0;
    end else if (stb.irqLoad) begin
      irqDelay <= stb.irqLoadNow ? '0 : DLY_FULL;
    end else if (stb.irqDec) begin
      irqDelay <= irqDelay - DLY_W'(1);
    end
  end

  always_comb begin
    status.wrapNext      = wrapNow;
    status.vbStartNext   = (CNT_W'(nextLine) == blankLine);
    status.firstVisNext  = (nextLine == FIRST_LINE);
    status.vMatchNext    = (nextLine == irqLine);
    status.hMatchNow     = (lineCount == irqLine);
    status.nmiCntLastOne = (nmiCnt == '0) || (nmiCnt == NMI_W'(1));
    status.irqDelayZero  = (irqDelay == '0);
    status.irqDelayOne   = (irqDelay == DLY_W'(1));
  end

  // The line count never leaves the longest frame.
  assert_line_in_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    CNT_W'(lineCount) < ANY_LIM);

  // The delay never exceeds its load value.
  assert_delay_bounded_R9: assert property (@(posedge clk) disable iff (!rstN)
    irqDelay <= DLY_FULL);

endmodule

// File: rtl/sirq_control.sv
module sirq_control
  import scanirq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineEndStb,
  input  logic             hTimerStb,
  input  logic             hTimerEn,
  input  logic             vTimerEn,
  input  logic [SRC_W-1:0] irqSrcClr,
  input  logic             nmiEnable,
  input  logic             cpuIrqMask,
  input  logic             cpuWaiting,
  input  dpStatus_t        status,
  output ctlStrobes_t      stb,
  output logic             nmiPulse,
  output logic             irqPulse,
  output logic             wakePulse,
  output logic             vblankFlag,
  output logic             fieldFlag
);

  logic             nmiPending;
  logic             irqPending;
  logic [SRC_W-1:0] irqSrc;
  logic [SRC_W-1:0] raiseBits;
  logic [SRC_W-1:0] keptSrc;
  logic             raiseAny;
  logic             vbEnter;
  logic             vbLeave;
  logic             nmiArm;
  logic             nmiFire;
  logic             irqSettle;
  logic             irqFire;
  logic             irqDrop;

  always_comb begin
    raiseBits        = '0;
    raiseBits[SRC_V] = lineEndStb & vTimerEn & ~hTimerEn & status.vMatchNext;
    raiseBits[SRC_H] = hTimerStb & hTimerEn & (~vTimerEn | status.hMatchNow);
    raiseAny         = |raiseBits;
    keptSrc          = irqSrc & ~irqSrcClr;

    vbEnter = lineEndStb & status.vbStartNext;
    vbLeave = lineEndStb & status.firstVisNext & ~status.vbStartNext;
    nmiArm  = vbEnter & nmiEnable;
    nmiFire = nmiPending & ~nmiArm & ~vbLeave & status.nmiCntLastOne;

    irqSettle = irqPending & ~raiseAny & status.irqDelayZero;
    irqFire   = irqSettle & (|keptSrc) & ~cpuIrqMask;
    irqDrop   = irqSettle & ~(|keptSrc);

    stb.lineAdv    = lineEndStb;
    stb.nmiLoad    = nmiArm;
    stb.nmiDec     = nmiPending & ~nmiArm & ~vbLeave & ~status.nmiCntLastOne;
    stb.irqLoad    = raiseAny;
    stb.irqLoadNow = raiseAny & cpuWaiting;
    stb.irqDec     = irqPending & ~raiseAny & ~status.irqDelayZero
                   & ~(status.irqDelayOne & cpuIrqMask);
  end

  // Frame status bits.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vblankFlag <= 1'b0;
      fieldFlag  <= 1'b0;
    end else begin
      if (vbEnter) begin
        vblankFlag <= 1'b1;
      end else if (vbLeave) begin
        vblankFlag <= 1'b0;
      end
      if (lineEndStb & status.wrapNext) begin
        fieldFlag <= ~fieldFlag;
      end
    end
  end

  // NMI pending state.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiPending <= 1'b0;
    end else if (nmiArm) begin
      nmiPending <= 1'b1;
    end else if (vbLeave | nmiFire) begin
      nmiPending <= 1'b0;
    end
  end

  // IRQ sources and pending state.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqSrc     <= '0;
      irqPending <= 1'b0;
    end else begin
      irqSrc <= keptSrc | raiseBits;
      if (raiseAny) begin
        irqPending <= 1'b1;
      end else if (irqFire | irqDrop) begin
        irqPending <= 1'b0;
      end
    end
  end

  // Registered pulse outputs.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiPulse  <= 1'b0;
      irqPulse  <= 1'b0;
      wakePulse <= 1'b0;
    end else begin
      nmiPulse  <= nmiFire;
      irqPulse  <= irqFire;
      wakePulse <= cpuWaiting & (raiseAny | nmiFire);
    end
  end

  assert_nmi_from_pending_R4: assert property (@(posedge clk) disable iff (!rstN)
    nmiPulse |-> $past(nmiPending));

  assert_nmi_single_R13: assert property (@(posedge clk) disable iff (!rstN)
    nmiPulse |=> !nmiPulse);

  assert_irq_unmasked_R11: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(irqPending && !cpuIrqMask));

  assert_wake_needs_wait_R10: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> $past(cpuWaiting));

  assert_vblank_on_line_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vblankFlag) |-> $past(lineEndStb));

  assert_field_on_line_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(fieldFlag) |-> $past(lineEndStb));

endmodule

// File: rtl/scanline_irq_ctrl.sv
module scanline_irq_ctrl
  import scanirq_pkg::*;
#(
  parameter int LINE_W     = 9,
  parameter int NTSC_LINES = 262,
  parameter int PAL_LINES  = 312,
  parameter int FIRST_VIS  = 1,
  parameter int NMI_W      = 4,
  parameter int IRQ_DELAY  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineEndStb,
  input  logic              hTimerStb,
  input  logic              palSel,
  input  logic [LINE_W-1:0] screenHeight,
  input  logic              hTimerEn,
  input  logic              vTimerEn,
  input  logic [LINE_W-1:0] irqLine,
  input  logic [1:0]        irqSrcClr,
  input  logic              nmiEnable,
  input  logic [NMI_W-1:0]  nmiTrigger,
  input  logic              cpuIrqMask,
  input  logic              cpuWaiting,
  output logic              nmiPulse,
  output logic              irqPulse,
  output logic              wakePulse,
  output logic              vblankFlag,
  output logic              fieldFlag
);

  ctlStrobes_t stbBus;
  dpStatus_t   statBus;

  sirq_datapath #(
    .LINE_W    (LINE_W),
    .NTSC_LINES(NTSC_LINES),
    .PAL_LINES (PAL_LINES),
    .FIRST_VIS (FIRST_VIS),
    .NMI_W     (NMI_W),
    .IRQ_DELAY (IRQ_DELAY)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .palSel      (palSel),
    .screenHeight(screenHeight),
    .irqLine     (irqLine),
    .nmiTrigger  (nmiTrigger),
    .stb         (stbBus),
    .status      (statBus)
  );

  sirq_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .lineEndStb(lineEndStb),
    .hTimerStb (hTimerStb),
    .hTimerEn  (hTimerEn),
    .vTimerEn  (vTimerEn),
    .irqSrcClr (irqSrcClr),
    .nmiEnable (nmiEnable),
    .cpuIrqMask(cpuIrqMask),
    .cpuWaiting(cpuWaiting),
    .status    (statBus),
    .stb       (stbBus),
    .nmiPulse  (nmiPulse),
    .irqPulse  (irqPulse),
    .wakePulse (wakePulse),
    .vblankFlag(vblankFlag),
    .fieldFlag (fieldFlag)
  );

endmodule

// File: tb/scanline_irq_ctrl_tb.sv
`timescale 1ns/1ps
module scanline_irq_ctrl_tb;

  localparam int LW  = 5;
  localparam int NT  = 12;
  localparam int PL  = 15;
  localparam int FV  = 1;
  localparam int NW  = 3;
  localparam int GAP = 10;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          lineEndStb = 1'b0;
  logic          hTimerStb = 1'b0;
  logic          palSel = 1'b0;
  logic [LW-1:0] screenHeight = '0;
  logic          hTimerEn = 1'b0;
  logic          vTimerEn = 1'b0;
  logic [LW-1:0] irqLine = '0;
  logic [1:0]    irqSrcClr = '0;
  logic          nmiEnable = 1'b0;
  logic [NW-1:0] nmiTrigger = '0;
  logic          cpuIrqMask = 1'b0;
  logic          cpuWaiting = 1'b0;
  logic          nmiPulse, irqPulse, wakePulse, vblankFlag, fieldFlag;

  int total = 0;
  int bad = 0;
  int mLine = 0;
  int mVb = 0;
  int mField = 0;

  always #4 clk = ~clk;

  scanline_irq_ctrl #(
    .LINE_W(LW), .NTSC_LINES(NT), .PAL_LINES(PL),
    .FIRST_VIS(FV), .NMI_W(NW), .IRQ_DELAY(3)
  ) u_dut (
    .clk(clk), .rstN(rstN), .lineEndStb(lineEndStb), .hTimerStb(hTimerStb),
    .palSel(palSel), .screenHeight(screenHeight), .hTimerEn(hTimerEn),
    .vTimerEn(vTimerEn), .irqLine(irqLine), .irqSrcClr(irqSrcClr),
    .nmiEnable(nmiEnable), .nmiTrigger(nmiTrigger), .cpuIrqMask(cpuIrqMask),
    .cpuWaiting(cpuWaiting), .nmiPulse(nmiPulse), .irqPulse(irqPulse),
    .wakePulse(wakePulse), .vblankFlag(vblankFlag), .fieldFlag(fieldFlag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nextOf(input int line);
    int lim;
    lim = palSel ? PL : NT;
    return (line + 1 >= lim) ? 0 : line + 1;
  endfunction

  task automatic modelAdvance();
    mLine = nextOf(mLine);
    if (mLine == 0) mField = mField ^ 1;
    if (mLine == int'(screenHeight) + FV) mVb = 1;
    else if (mLine == FV) mVb = 0;
  endtask

  // Drive one stimulus and watch GAP edges. Expected values are edge
  // counts, the strobe edge being 1; 0 means no pulse in the window.
  task automatic doStep(input bit ls, input bit hs, input logic [1:0] clr,
                        input int eIrq, input int eNmi, input int eWake,
                        input string tag);
    int fI, fN, fW, cI, cN, cW;
    fI = 0; fN = 0; fW = 0; cI = 0; cN = 0; cW = 0;
    @(negedge clk);
    lineEndStb = ls;
    hTimerStb  = hs;
    if (ls) modelAdvance();
    for (int k = 1; k <= GAP; k++) begin
      @(negedge clk);
      if (k == 1) begin
        lineEndStb = 1'b0;
        hTimerStb  = 1'b0;
        irqSrcClr  = clr;
        if (ls) begin
          chk(int'(vblankFlag) == mVb, {tag, " R1 R3 vblank"}, int'(vblankFlag), mVb);
          chk(int'(fieldFlag) == mField, {tag, " R1 R2 field"}, int'(fieldFlag), mField);
        end
      end else if (k == 2) begin
        irqSrcClr = 2'b00;
      end
      if (irqPulse)  begin cI++; if (fI == 0) fI = k; end
      if (nmiPulse)  begin cN++; if (fN == 0) fN = k; end
      if (wakePulse) begin cW++; if (fW == 0) fW = k; end
    end
    chk(cI == ((eIrq != 0) ? 1 : 0) && fI == eIrq, {tag, " irq edge"}, fI, eIrq);
    chk(cN == ((eNmi != 0) ? 1 : 0) && fN == eNmi, {tag, " nmi edge"}, fN, eNmi);
    chk(cW == ((eWake != 0) ? 1 : 0) && fW == eWake, {tag, " wake edge"}, fW, eWake);
  endtask

  task automatic stepLine(input string tag);
    int nl, eN, eI, eW;
    nl = nextOf(mLine);
    eN = 0; eI = 0; eW = 0;
    if (nmiEnable && nl == int'(screenHeight) + FV)
      eN = ((nmiTrigger == 0) ? 1 : int'(nmiTrigger)) + 1;
    if (vTimerEn && !hTimerEn && nl == int'(irqLine))
      eI = cpuWaiting ? 2 : 5;
    if (cpuWaiting && eI != 0) eW = 1;
    else if (cpuWaiting && eN != 0) eW = eN;
    doStep(1'b1, 1'b0, 2'b00, eI, eN, eW, tag);
  endtask

  task automatic stepH(input string tag);
    int eI, eW;
    eI = 0; eW = 0;
    if (hTimerEn && (!vTimerEn || mLine == int'(irqLine)))
      eI = cpuWaiting ? 2 : 5;
    if (cpuWaiting && eI != 0) eW = 1;
    doStep(1'b0, 1'b1, 2'b00, eI, 0, eW, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog R13 actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    screenHeight = LW'(8);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R13: reset state of every output
    chk(!nmiPulse && !irqPulse && !wakePulse, "R13 pulses", int'(nmiPulse | irqPulse | wakePulse), 0);
    chk(!vblankFlag && !fieldFlag, "R13 flags", int'(vblankFlag | fieldFlag), 0);

    // R1 R2 R3: two NTSC frames, then two PAL frames
    repeat (2 * NT) stepLine("R1 ntsc");
    palSel = 1'b1;
    screenHeight = LW'(10);
    repeat (2 * PL) stepLine("R1 pal");
    palSel = 1'b0;
    screenHeight = LW'(8);

    // R4: every trigger value, one frame each
    nmiEnable = 1'b1;
    for (int t = 0; t < (1 << NW); t++) begin
      nmiTrigger = NW'(t);
      repeat (NT) stepLine("R4 trigger");
    end

    // R5: disabled NMI
    nmiEnable = 1'b0;
    repeat (NT) stepLine("R5 disabled");

    // R5: cancel by reaching the first visible line
    screenHeight = LW'(10);
    while (mLine != 10) stepLine("R5 approach");
    nmiEnable  = 1'b1;
    nmiTrigger = NW'(7);
    @(negedge clk);
    lineEndStb = 1'b1;
    modelAdvance();
    @(negedge clk);
    modelAdvance();
    @(negedge clk);
    modelAdvance();
    @(negedge clk);
    lineEndStb = 1'b0;
    chk(int'(vblankFlag) == mVb && mVb == 0, "R5 R3 vblank after burst", int'(vblankFlag), mVb);
    chk(!nmiPulse, "R5 no nmi during burst", int'(nmiPulse), 0);
    doStep(1'b0, 1'b0, 2'b00, 0, 0, 0, "R5 cancelled");
    nmiEnable = 1'b0;
    screenHeight = LW'(8);

    // R6: NMI wakes a waiting CPU
    cpuWaiting = 1'b1;
    nmiEnable  = 1'b1;
    nmiTrigger = NW'(2);
    repeat (NT) stepLine("R6 wake");
    cpuWaiting = 1'b0;
    nmiEnable  = 1'b0;

    // R7 R9: vertical-only sweep over all target lines
    vTimerEn = 1'b1;
    hTimerEn = 1'b0;
    for (int tgt = 0; tgt < NT; tgt++) begin
      irqLine = LW'(tgt);
      repeat (NT) stepLine("R7 R9 vertical");
    end
    stepH("R7 hstrobe ignored");

    // R10: waiting CPU, vertical-only
    cpuWaiting = 1'b1;
    irqLine = LW'(5);
    repeat (NT) stepLine("R10 waiting");
    cpuWaiting = 1'b0;

    // R8: horizontal-only, gated, and disabled
    vTimerEn = 1'b0;
    hTimerEn = 1'b1;
    repeat (NT) begin stepH("R8 h only"); stepLine("R8 h only"); end
    vTimerEn = 1'b1;
    irqLine = LW'(3);
    repeat (NT) begin stepH("R8 gated"); stepLine("R8 gated"); end
    vTimerEn = 1'b0;
    hTimerEn = 1'b0;
    repeat (NT) begin stepH("R8 off"); stepLine("R8 off"); end

    // R10: horizontal raise while waiting
    hTimerEn = 1'b1;
    cpuWaiting = 1'b1;
    stepH("R10 h waiting");
    cpuWaiting = 1'b0;

    // R11: masked IRQ stays pending, released later
    cpuIrqMask = 1'b1;
    doStep(1'b0, 1'b1, 2'b00, 0, 0, 0, "R11 masked");
    doStep(1'b0, 1'b0, 2'b00, 0, 0, 0, "R11 still masked");
    cpuIrqMask = 1'b0;
    doStep(1'b0, 1'b0, 2'b00, 1, 0, 0, "R11 released");

    // R12: clearing all sources cancels, clearing another does not
    doStep(1'b0, 1'b1, 2'b11, 0, 0, 0, "R12 clear all");
    doStep(1'b0, 1'b1, 2'b10, 5, 0, 0, "R12 clear other");
    doStep(1'b0, 1'b1, 2'b01, 0, 0, 0, "R12 clear h");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule